// File: doc/BRIEF.md
# Lookup Coprocessor External SRAM Read Sequencer

This block is the device-side controller that answers a host's read of the external SRAM attached to a lookup coprocessor. The host issues the read as two back-to-back command cycles on a strobe, a 9-bit command bus and a 68-bit shared data/address bus. Each device on a shared table compares a 5-bit field in that bus with its own strapped identifier. Only the device whose identifier matches owns the transfer.

The owning device waits two quiet cycles so the host can turn the shared bus around. It then drives the bus, raises a response line through a fixed low-high-low pattern, and presents the SRAM address together with chip-select, write-enable and latch-enable for exactly one cycle. It releases every pin on a fixed schedule, so a new command can begin in the eighth cycle.

Devices whose identifier does not match follow the same seven-cycle schedule silently. They treat the bus traffic inside it as belonging to the running transfer. Every tri-state pin is modelled as a value plus an output-enable.

Top module: `sr_read_seq`

## Requirements
- R1: While reset is asserted, and until the first accepted command, every output-enable (bus, response, SRAM address, chip-select, write-enable, latch-enable) is 0.
- R2: A read is accepted only when two consecutive cycles both show the strobe at 1, command bits [1:0] equal to 2'b00 and bus bits [20:19] equal to 2'b10. If the first cycle fails, nothing happens. If the second cycle fails, no pin is ever driven and the very next cycle may serve as a new first cycle.
- R3: The device owns the transfer only when bus bits [25:21] of the first cycle equal its identifier. Otherwise all enables stay 0 for cycles 2 to 8.
- R4: The SRAM address driven in cycle 6 is {command bits [8:7], bus bits [45:26]}, both taken from the first command cycle.
- R5: The owner keeps the bus undriven in cycles 2 and 3. It drives it in cycles 4, 5 and 6 with the word seen on the bus in the second command cycle, and releases it in cycle 7.
- R6: The owner's response enable is 0 through cycle 4. The response is driven 0 in cycle 5, 1 in cycle 6 and 0 in cycle 7, and is released in cycle 8.
- R7: In cycle 6 only, the owner drives the SRAM address, chip-select low, write-enable high and latch-enable low. All of these are released in every other cycle.
- R8: A new first command cycle is accepted in cycle 8, with no idle cycle after the previous transfer.
- R9: Command-like traffic that arrives during cycles 2 to 7 of a running transfer, owned or not, is ignored and does not change the schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| my_id_i | input | 5 | Strapped device identifier |
| op_vld_i | input | 1 | Command strobe |
| op_i | input | 9 | Command bus: opcode in [1:0], upper SRAM address in [8:7] |
| bus_i | input | 68 | Shared bus as seen by the device |
| bus_o | output | 68 | Value the device drives onto the shared bus |
| bus_oe_o | output | 1 | Shared bus output-enable |
| resp_o | output | 1 | Response line value |
| resp_oe_o | output | 1 | Response line output-enable |
| ram_addr_o | output | 22 | SRAM address value |
| ram_addr_oe_o | output | 1 | SRAM address output-enable |
| ram_cs_n_o | output | 1 | SRAM chip-select value, active low |
| ram_cs_oe_o | output | 1 | Chip-select output-enable |
| ram_wr_n_o | output | 1 | SRAM write-enable value, active low |
| ram_wr_oe_o | output | 1 | Write-enable output-enable |
| ram_latch_n_o | output | 1 | SRAM address latch-enable value, active low |
| ram_latch_oe_o | output | 1 | Latch-enable output-enable |

## Verification
The output properties assume that reset is never pulsed in the middle of a transfer. They also assume the identifier strap stays constant and every input carries a known value at each clock edge. Given those inputs, the only legal orderings of the enables are the seven-cycle pattern and full release. The stimulus holds the identifier fixed and drives random but fully defined words on idle cycles. It places command-like traffic only inside running transfers or as deliberately broken first or second command cycles, and it asserts reset only once, at the start.

// File: rtl/sr_read_pkg.sv
package sr_read_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HALF,
    ST_GAP1,
    ST_GAP2,
    ST_DRV1,
    ST_DRV2,
    ST_STRB,
    ST_TAIL
  } seq_st_e;

  typedef struct packed {
    logic bus_oe;
    logic resp_oe;
    logic resp;
    logic addr_oe;
    logic strb_oe;
  } pin_plan_t;

  // Pin schedule for the state the sequencer is about to enter.
  function automatic pin_plan_t plan_for(seq_st_e st, logic own);
    pin_plan_t p;
    p = '0;
    if (own) begin
      case (st)
        ST_DRV1: p.bus_oe = 1'b1;
        ST_DRV2: begin
          p.bus_oe  = 1'b1;
          p.resp_oe = 1'b1;
        end
        ST_STRB: begin
          p.bus_oe  = 1'b1;
          p.resp_oe = 1'b1;
          p.resp    = 1'b1;
          p.addr_oe = 1'b1;
          p.strb_oe = 1'b1;
        end
        ST_TAIL: p.resp_oe = 1'b1;
        default: p = '0;
      endcase
    end
    return p;
  endfunction

endpackage

// File: rtl/sr_rst_sync.sv
module sr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= 1'b1;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/sr_cmd_check.sv
module sr_cmd_check #(
  parameter int         ID_W    = 5,
  parameter int         ADDR_W  = 22,
  parameter int         ALO_W   = 20,
  parameter logic [1:0] READ_OP = 2'b00,
  parameter logic [1:0] SEL_VAL = 2'b10,
  localparam int        AHI_W   = ADDR_W - ALO_W
) (
  input  logic              op_vld,
  input  logic [1:0]        op_code,
  input  logic [AHI_W-1:0]  op_ahi,
  input  logic [1:0]        sel_fld,
  input  logic [ID_W-1:0]   id_fld,
  input  logic [ALO_W-1:0]  alo_fld,
  input  logic [ID_W-1:0]   my_id,
  output logic              cmd_ok,
  output logic              id_hit,
  output logic [ADDR_W-1:0] addr
);

  always_comb begin
    cmd_ok = op_vld && (op_code == READ_OP) && (sel_fld == SEL_VAL);
    id_hit = (id_fld == my_id);
    addr   = {op_ahi, alo_fld};
  end

endmodule

// File: rtl/sr_seq_fsm.sv
module sr_seq_fsm
  import sr_read_pkg::*;
#(
  parameter int BUS_W  = 68,
  parameter int ADDR_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_ok,
  input  logic              id_hit,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [BUS_W-1:0]  word_in,
  output seq_st_e           st_nxt_o,
  output logic              own_nxt_o,
  output logic [ADDR_W-1:0] addr_q_o,
  output logic [BUS_W-1:0]  word_q_o
);

  seq_st_e           st_q, st_d;
  logic              own_q, own_d;
  logic              cap_a, cap_b;
  logic [ADDR_W-1:0] addr_q;
  logic [BUS_W-1:0]  word_q;

  always_comb begin
    st_d  = st_q;
    own_d = own_q;
    cap_a = 1'b0;
    cap_b = 1'b0;
    case (st_q)
      ST_IDLE: begin
        own_d = 1'b0;
        if (cmd_ok) begin
          st_d  = ST_HALF;
          own_d = id_hit;
          cap_a = 1'b1;
        end
      end
      ST_HALF: begin
        if (cmd_ok) begin
          st_d  = ST_GAP1;
          cap_b = 1'b1;
        end else begin
          st_d  = ST_IDLE;
          own_d = 1'b0;
        end
      end
      ST_GAP1: st_d = ST_GAP2;
      ST_GAP2: st_d = ST_DRV1;
      ST_DRV1: st_d = ST_DRV2;
      ST_DRV2: st_d = ST_STRB;
      ST_STRB: st_d = ST_TAIL;
      ST_TAIL: begin
        st_d  = ST_IDLE;
        own_d = 1'b0;
      end
      default: begin
        st_d  = ST_IDLE;
        own_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      own_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      own_q <= own_d;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_a) addr_q <= addr_in;
  end

  always_ff @(posedge clk) begin
    if (cap_b) word_q <= word_in;
  end

  assign st_nxt_o  = st_d;
  assign own_nxt_o = own_d;
  assign addr_q_o  = addr_q;
  assign word_q_o  = word_q;

endmodule

// File: rtl/sr_pin_drive.sv
module sr_pin_drive
  import sr_read_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  seq_st_e st_nxt,
  input  logic    own_nxt,
  output logic    bus_oe,
  output logic    resp,
  output logic    resp_oe,
  output logic    addr_oe,
  output logic    cs_n,
  output logic    cs_oe,
  output logic    wr_oe,
  output logic    latch_n,
  output logic    latch_oe
);

  pin_plan_t plan;

  always_comb plan = plan_for(st_nxt, own_nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_oe   <= 1'b0;
      resp     <= 1'b0;
      resp_oe  <= 1'b0;
      addr_oe  <= 1'b0;
      cs_n     <= 1'b1;
      cs_oe    <= 1'b0;
      wr_oe    <= 1'b0;
      latch_n  <= 1'b1;
      latch_oe <= 1'b0;
    end else begin
      bus_oe   <= plan.bus_oe;
      resp     <= plan.resp;
      resp_oe  <= plan.resp_oe;
      addr_oe  <= plan.addr_oe;
      cs_n     <= !plan.strb_oe;
      cs_oe    <= plan.strb_oe;
      wr_oe    <= plan.strb_oe;
      latch_n  <= !plan.strb_oe;
      latch_oe <= plan.strb_oe;
    end
  end

endmodule

// File: rtl/sr_read_seq.sv
module sr_read_seq
  import sr_read_pkg::*;
#(
  parameter int         BUS_W    = 68,
  parameter int         ADDR_W   = 22,
  parameter int         ID_W     = 5,
  parameter int         OP_W     = 9,
  parameter int         ALO_W    = 20,
  parameter int         SEL_LSB  = 19,
  parameter int         ID_LSB   = 21,
  parameter int         ALO_LSB  = 26,
  parameter int         AHI_LSB  = 7,
  parameter int         SYNC_STG = 2,
  parameter logic [1:0] READ_OP  = 2'b00,
  parameter logic [1:0] SEL_VAL  = 2'b10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   my_id_i,
  input  logic              op_vld_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [BUS_W-1:0]  bus_i,
  output logic [BUS_W-1:0]  bus_o,
  output logic              bus_oe_o,
  output logic              resp_o,
  output logic              resp_oe_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic              ram_addr_oe_o,
  output logic              ram_cs_n_o,
  output logic              ram_cs_oe_o,
  output logic              ram_wr_n_o,
  output logic              ram_wr_oe_o,
  output logic              ram_latch_n_o,
  output logic              ram_latch_oe_o
);

  localparam int AHI_W = ADDR_W - ALO_W;

  logic              rst_sync_n;
  logic              cmd_ok;
  logic              id_hit;
  logic [ADDR_W-1:0] addr_cmb;
  seq_st_e           st_nxt;
  logic              own_nxt;
  logic              op_mid_unused;

  assign op_mid_unused = ^op_i[AHI_LSB-1:2];

  sr_rst_sync #(
    .STAGES(SYNC_STG)
  ) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sr_cmd_check #(
    .ID_W    (ID_W),
    .ADDR_W  (ADDR_W),
    .ALO_W   (ALO_W),
    .READ_OP (READ_OP),
    .SEL_VAL (SEL_VAL)
  ) cmd_check_i (
    .op_vld  (op_vld_i),
    .op_code (op_i[1:0]),
    .op_ahi  (op_i[AHI_LSB +: AHI_W]),
    .sel_fld (bus_i[SEL_LSB +: 2]),
    .id_fld  (bus_i[ID_LSB +: ID_W]),
    .alo_fld (bus_i[ALO_LSB +: ALO_W]),
    .my_id   (my_id_i),
    .cmd_ok  (cmd_ok),
    .id_hit  (id_hit),
    .addr    (addr_cmb)
  );

  sr_seq_fsm #(
    .BUS_W  (BUS_W),
    .ADDR_W (ADDR_W)
  ) seq_fsm_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cmd_ok    (cmd_ok),
    .id_hit    (id_hit),
    .addr_in   (addr_cmb),
    .word_in   (bus_i),
    .st_nxt_o  (st_nxt),
    .own_nxt_o (own_nxt),
    .addr_q_o  (ram_addr_o),
    .word_q_o  (bus_o)
  );

  sr_pin_drive pin_drive_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .st_nxt   (st_nxt),
    .own_nxt  (own_nxt),
    .bus_oe   (bus_oe_o),
    .resp     (resp_o),
    .resp_oe  (resp_oe_o),
    .addr_oe  (ram_addr_oe_o),
    .cs_n     (ram_cs_n_o),
    .cs_oe    (ram_cs_oe_o),
    .wr_oe    (ram_wr_oe_o),
    .latch_n  (ram_latch_n_o),
    .latch_oe (ram_latch_oe_o)
  );

  assign ram_wr_n_o = 1'b1;

endmodule

// File: rtl/sr_read_seq_chk.sv
module sr_read_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_oe_o,
  input logic resp_o,
  input logic resp_oe_o,
  input logic ram_addr_oe_o,
  input logic ram_cs_n_o,
  input logic ram_cs_oe_o,
  input logic ram_wr_n_o,
  input logic ram_latch_n_o
);

  // R7
  strobe_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_cs_oe_o |-> (resp_oe_o && resp_o && ram_addr_oe_o && bus_oe_o));

  // R7
  strobe_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_cs_oe_o |-> (!ram_cs_n_o && ram_wr_n_o && !ram_latch_n_o));

  // R7
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_cs_oe_o |=> (!ram_cs_oe_o && resp_oe_o && !resp_o && !bus_oe_o));

  // R6
  resp_start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resp_oe_o) |-> (!resp_o && bus_oe_o));

  // R5
  bus_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe_o) |-> (!resp_oe_o && !ram_cs_oe_o));

  // R5
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe_o) |=> bus_oe_o);

  // R6
  resp_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_oe_o && !resp_o && !bus_oe_o) |=> !resp_oe_o);

endmodule

bind sr_read_seq sr_read_seq_chk chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_oe_o      (bus_oe_o),
  .resp_o        (resp_o),
  .resp_oe_o     (resp_oe_o),
  .ram_addr_oe_o (ram_addr_oe_o),
  .ram_cs_n_o    (ram_cs_n_o),
  .ram_cs_oe_o   (ram_cs_oe_o),
  .ram_wr_n_o    (ram_wr_n_o),
  .ram_latch_n_o (ram_latch_n_o)
);

// File: tb/sr_read_seq_tb.sv
module sr_read_seq_tb_top;

  typedef logic [67:0] w_t;
  localparam logic [4:0] MY_ID = 5'h13;

  logic        clk;
  logic        rst_n;
  logic [4:0]  my_id_i;
  logic        op_vld_i;
  logic [8:0]  op_i;
  logic [67:0] bus_i;
  logic [67:0] bus_o;
  logic        bus_oe_o, resp_o, resp_oe_o;
  logic [21:0] ram_addr_o;
  logic        ram_addr_oe_o, ram_cs_n_o, ram_cs_oe_o, ram_wr_n_o, ram_wr_oe_o;
  logic        ram_latch_n_o, ram_latch_oe_o;

  int checks;
  int fails;

  sr_read_seq dut_i (
    .clk(clk), .rst_n(rst_n), .my_id_i(my_id_i), .op_vld_i(op_vld_i),
    .op_i(op_i), .bus_i(bus_i), .bus_o(bus_o), .bus_oe_o(bus_oe_o),
    .resp_o(resp_o), .resp_oe_o(resp_oe_o), .ram_addr_o(ram_addr_o),
    .ram_addr_oe_o(ram_addr_oe_o), .ram_cs_n_o(ram_cs_n_o),
    .ram_cs_oe_o(ram_cs_oe_o), .ram_wr_n_o(ram_wr_n_o),
    .ram_wr_oe_o(ram_wr_oe_o), .ram_latch_n_o(ram_latch_n_o),
    .ram_latch_oe_o(ram_latch_oe_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(string req, w_t act, w_t exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic w_t rnd_word();
    return w_t'({$urandom(), $urandom(), $urandom()});
  endfunction

  task automatic drive_idle();
    op_vld_i = 1'b0;
    op_i     = 9'($urandom());
    bus_i    = rnd_word();
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Expected pins for cycle c of a transfer (c = 0 means no transfer).
  task automatic check_cycle(int c, bit own, logic [21:0] ea, w_t ew, string ctx);
    bit e_bus, e_roe, e_rv, e_strb;
    e_bus  = own && (c >= 4) && (c <= 6);
    e_roe  = own && (c >= 5) && (c <= 7);
    e_rv   = (c == 6);
    e_strb = own && (c == 6);
    chk({"R5 bus enable ", ctx}, w_t'(bus_oe_o), w_t'(e_bus));
    if (e_bus) chk({"R5 bus word ", ctx}, bus_o, ew);
    chk({"R6 response enable ", ctx}, w_t'(resp_oe_o), w_t'(e_roe));
    if (e_roe) chk({"R6 response level ", ctx}, w_t'(resp_o), w_t'(e_rv));
    chk({"R7 strobe enables ", ctx},
        w_t'({ram_addr_oe_o, ram_cs_oe_o, ram_wr_oe_o, ram_latch_oe_o}),
        w_t'({4{e_strb}}));
    if (e_strb) begin
      chk({"R4 sram address ", ctx}, w_t'(ram_addr_o), w_t'(ea));
      chk({"R7 strobe levels ", ctx},
          w_t'({ram_cs_n_o, ram_wr_n_o, ram_latch_n_o}), w_t'(3'b010));
    end
  endtask

  // bkind: 0 good second cycle, 1 strobe low, 2 wrong opcode, 3 wrong select field
  task automatic run_seq(bit match, int bkind, bit inject, string ctx);
    logic [4:0]  id_sent;
    logic [1:0]  ahi;
    logic [19:0] alo;
    w_t          wa, wb;
    id_sent = match ? MY_ID : (MY_ID ^ 5'(1 + ($urandom() % 31)));
    ahi     = 2'($urandom());
    alo     = 20'($urandom());
    wa      = rnd_word();
    wa[20:19] = 2'b10;
    wa[25:21] = id_sent;
    wa[45:26] = alo;
    wb      = rnd_word();
    wb[20:19] = 2'b10;
    // first command cycle
    op_vld_i = 1'b1;
    op_i     = {ahi, 5'($urandom()), 2'b00};
    bus_i    = wa;
    step();
    // second command cycle
    op_vld_i = (bkind != 1);
    op_i     = {2'($urandom()), 5'($urandom()), (bkind == 2) ? 2'b01 : 2'b00};
    if (bkind == 3) wb[20:19] = 2'b11;
    bus_i    = wb;
    step();
    if (bkind != 0) begin
      check_cycle(0, 1'b0, '0, '0, {"R2 bad second cycle ", ctx});
      drive_idle();
      return;
    end
    for (int c = 2; c <= 7; c++) begin
      check_cycle(c, match, {ahi, alo}, wb, match ? ctx : {"R3 ", ctx});
      if (inject && (c == 4 || c == 5)) begin
        op_vld_i = 1'b1;
        op_i     = 9'b0;
        bus_i    = rnd_word();
        bus_i[20:19] = 2'b10;
        bus_i[25:21] = MY_ID;
      end else begin
        drive_idle();
      end
      step();
    end
    // cycle 8: all released
    check_cycle(8, match, {ahi, alo}, wb, {"R6 release ", ctx});
  endtask

  initial begin
    checks   = 0;
    fails    = 0;
    rst_n    = 1'b0;
    my_id_i  = MY_ID;
    void'($urandom(32'd20240611));
    drive_idle();
    repeat (4) @(negedge clk);
    chk("R1 enables in reset",
        w_t'({bus_oe_o, resp_oe_o, ram_addr_oe_o, ram_cs_oe_o, ram_wr_oe_o, ram_latch_oe_o}),
        w_t'(0));
    rst_n = 1'b1;
    repeat (3) step();
    check_cycle(0, 1'b0, '0, '0, "R1 after reset");

    // directed corner cases
    run_seq(1'b1, 0, 1'b0, "basic");
    run_seq(1'b1, 0, 1'b0, "R8 back-to-back");
    run_seq(1'b0, 0, 1'b0, "R3 other id");
    run_seq(1'b1, 0, 1'b0, "R8 after unowned");
    run_seq(1'b1, 0, 1'b1, "R9 owned injection");
    run_seq(1'b0, 0, 1'b1, "R9 unowned injection");
    run_seq(1'b1, 1, 1'b0, "R2 strobe low");
    run_seq(1'b1, 2, 1'b0, "R2 wrong opcode");
    run_seq(1'b1, 3, 1'b0, "R2 wrong select");
    run_seq(1'b1, 0, 1'b0, "R2 restart after failed second");

    // first cycle with a wrong select field, then a write opcode
    for (int k = 0; k < 2; k++) begin
      op_vld_i = 1'b1;
      op_i     = (k == 0) ? 9'h000 : 9'h001;
      bus_i    = rnd_word();
      bus_i[20:19] = (k == 0) ? 2'b01 : 2'b10;
      bus_i[25:21] = MY_ID;
      step();
      for (int c = 0; c < 6; c++) begin
        drive_idle();
        check_cycle(0, 1'b0, '0, '0, "R2 rejected first cycle");
        step();
      end
    end

    // constrained random transfers
    for (int n = 0; n < 220; n++) begin
      bit match, inject;
      int bkind, gap;
      match  = ($urandom() % 4) != 0;
      bkind  = (($urandom() % 5) == 0) ? int'(1 + ($urandom() % 3)) : 0;
      inject = ($urandom() % 6) == 0;
      gap    = int'($urandom() % 3);
      for (int g = 0; g < gap; g++) begin
        drive_idle();
        check_cycle(0, 1'b0, '0, '0, "R2 idle gap");
        step();
      end
      run_seq(match, bkind, inject, (gap == 0) ? "R8 random" : "random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule